// File: doc/BRIEF.md
# Shared Channel Ownership Arbiter

This block decides which of two masters may drive a single shared auxiliary channel. One master is the host software port. The other is an embedded microcontroller port. Each master has a request line and a release line.

Ownership appears as a registered 2-bit code that the host can read. An availability flag beside it tells the host whether the microcontroller currently holds the channel. Ownership goes to whichever master asks first. When both ask in the same cycle, the microcontroller wins. The owner keeps the channel until it releases it, and a release from a master that does not own the channel does nothing.

The block also holds the channel enable bit and the channel reset bit. Before the host first uses the channel, it writes both bits high together and waits for the reset-done flag to rise. It then clears the reset bit and waits for the flag to fall. The reset-done flag follows the reset bit after a fixed number of cycles, set by `RST_LAT`.

Top module: `chan_own_arbiter`

## Requirements
- R1: The ownership code is 0 for idle, 1 for host-owns and 2 for controller-owns, and it never takes the value 3. After reset the code is 0, `avail` is 1, and `chan_en`, `chan_rst` and `rst_done` are 0.
- R2: When the code is idle and `host_req` is high while `mcu_req` is low at a clock edge, the code is 1 after that edge.
- R3: `avail` is 1 in every cycle in which the code is not 2, and 0 in every cycle in which it is 2.
- R4: When the code is idle and both request lines are high at the same edge, the code becomes 2.
- R5: A host request while the code is 2 leaves the code at 2.
- R6: `host_done` while the code is 1 returns the code to 0 at the next edge, even if `host_req` is also high.
- R7: `mcu_done` while the code is 2 returns the code to 0 at the next edge.
- R8: A release from a master that is not the owner leaves the code unchanged. This covers `host_done` while the code is 2, `mcu_done` while it is 1, and either release while it is 0.
- R9: `mcu_req` while the code is 1 leaves the code at 1. A controller that keeps requesting is granted at the first edge at which the code is idle.
- R10: A write strobe `ctl_wr` loads `ctl_en` into `chan_en` and `ctl_rst` into `chan_rst` at the same edge, so enable and reset can be raised together.
- R11: `rst_done` equals the value `chan_rst` had `RST_LAT` clock edges earlier. With the default of 3, `rst_done` rises at the third edge after the edge that set `chan_rst`, and falls the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host asks for the channel |
| host_done | input | 1 | Host releases the channel |
| mcu_req | input | 1 | Microcontroller asks for the channel |
| mcu_done | input | 1 | Microcontroller releases the channel |
| ctl_wr | input | 1 | Write strobe for the enable and reset bits |
| ctl_en | input | 1 | Enable value to write |
| ctl_rst | input | 1 | Reset value to write |
| own_status | output | 2 | Ownership code: 0 idle, 1 host, 2 controller |
| avail | output | 1 | High unless the controller owns the channel |
| chan_en | output | 1 | Channel enable bit |
| chan_rst | output | 1 | Channel reset bit |
| rst_done | output | 1 | Reset-done flag, delayed copy of `chan_rst` |

## Verification
The in-line assertions check several rules on every cycle:
- the code is never 3;
- `avail` matches the code;
- controller priority from idle;
- the host cannot take or drop a channel the controller holds;
- the controller cannot take or drop a channel the host holds;
- a control write lands in both bits;
- `rst_done` agrees with `chan_rst` once that bit has been steady for the latency window.

Only the bench scenarios show the exact edge at which `rst_done` moves relative to each reset-bit write, the full enable, reset and release handshake, and the hand-over to a controller that has been waiting while the host releases.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_MCU  = 2'd2
  } owner_e;
endpackage

// File: rtl/own_arb_core.sv
module own_arb_core
  import chan_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       host_req,
  input  logic       host_done,
  input  logic       mcu_req,
  input  logic       mcu_done,
  output logic [1:0] own_status,
  output logic       avail
);
  owner_e own_q, own_d;

  always_comb begin
    own_d = own_q;
    unique case (own_q)
      OWN_IDLE: begin
        if (mcu_req)       own_d = OWN_MCU;
        else if (host_req) own_d = OWN_HOST;
      end
      OWN_HOST: if (host_done) own_d = OWN_IDLE;
      OWN_MCU:  if (mcu_done)  own_d = OWN_IDLE;
      default:  own_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= OWN_IDLE;
      avail <= 1'b1;
    end else begin
      own_q <= own_d;
      avail <= (own_d != OWN_MCU);
    end
  end

  assign own_status = own_q;

  // R1
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    own_status != 2'd3);
  // R3
  avail_match_chk: assert property (@(posedge clk) disable iff (rst)
    avail == (own_status != 2'd2));
  // R4
  mcu_first_chk: assert property (@(posedge clk) disable iff (rst)
    (own_status == 2'd0 && mcu_req) |=> own_status == 2'd2);
  // R5
  mcu_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (own_status == 2'd2 && !mcu_done) |=> own_status == 2'd2);
  // R9
  host_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (own_status == 2'd1 && !host_done) |=> own_status == 2'd1);
endmodule

// File: rtl/rst_handshake.sv
module rst_handshake #(
  parameter int RST_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic ctl_en,
  input  logic ctl_rst,
  output logic chan_en,
  output logic chan_rst,
  output logic rst_done
);
  localparam int CW = $clog2(RST_LAT + 1) + 1;

  logic [RST_LAT-1:0] dly_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en  <= 1'b0;
      chan_rst <= 1'b0;
    end else if (ctl_wr) begin
      chan_en  <= ctl_en;
      chan_rst <= ctl_rst;
    end
  end

  generate
    if (RST_LAT == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) dly_q <= '0;
        else     dly_q <= chan_rst;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) dly_q <= '0;
        else     dly_q <= {dly_q[RST_LAT-2:0], chan_rst};
      end
    end
  endgenerate

  assign rst_done = dly_q[RST_LAT-1];

  // window checker: cycles chan_rst has been steady
  logic          rst_prev;
  logic [CW-1:0] steady_cnt;
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_prev   <= 1'b0;
      steady_cnt <= '0;
    end else begin
      rst_prev <= chan_rst;
      if (chan_rst != rst_prev)          steady_cnt <= '0;
      else if (steady_cnt < CW'(RST_LAT)) steady_cnt <= steady_cnt + 1'b1;
    end
  end

  // R10
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (chan_en == $past(ctl_en) && chan_rst == $past(ctl_rst)));
  // R11
  done_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_rst == rst_prev && steady_cnt >= CW'(RST_LAT - 1)) |-> rst_done == chan_rst);
endmodule

// File: rtl/chan_own_arbiter.sv
module chan_own_arbiter #(
  parameter int RST_LAT = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_req,
  input  logic       host_done,
  input  logic       mcu_req,
  input  logic       mcu_done,
  input  logic       ctl_wr,
  input  logic       ctl_en,
  input  logic       ctl_rst,
  output logic [1:0] own_status,
  output logic       avail,
  output logic       chan_en,
  output logic       chan_rst,
  output logic       rst_done
);
  own_arb_core u_core (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_done  (host_done),
    .mcu_req    (mcu_req),
    .mcu_done   (mcu_done),
    .own_status (own_status),
    .avail      (avail)
  );

  rst_handshake #(.RST_LAT(RST_LAT)) u_hs (
    .clk      (clk),
    .rst      (rst),
    .ctl_wr   (ctl_wr),
    .ctl_en   (ctl_en),
    .ctl_rst  (ctl_rst),
    .chan_en  (chan_en),
    .chan_rst (chan_rst),
    .rst_done (rst_done)
  );
endmodule

// File: tb/test_chan_own_arbiter.sv
module test_chan_own_arbiter;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_req = 0, host_done = 0, mcu_req = 0, mcu_done = 0;
  logic ctl_wr = 0, ctl_en = 0, ctl_rst = 0;
  logic [1:0] own_status;
  logic avail, chan_en, chan_rst, rst_done;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  chan_own_arbiter #(.RST_LAT(LAT)) i_chan_own_arbiter (
    .clk(clk), .rst(rst), .host_req(host_req), .host_done(host_done),
    .mcu_req(mcu_req), .mcu_done(mcu_done), .ctl_wr(ctl_wr), .ctl_en(ctl_en),
    .ctl_rst(ctl_rst), .own_status(own_status), .avail(avail),
    .chan_en(chan_en), .chan_rst(chan_rst), .rst_done(rst_done)
  );

  // behavioural reference
  int m_own = 0, m_av = 1, m_en = 0, m_rst = 0, m_done = 0;
  int hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_own = 0; m_av = 1; m_en = 0; m_rst = 0; m_done = 0;
      hist.delete();
      for (int i = 0; i < LAT; i++) hist.push_back(0);
    end else begin
      if (m_own == 0) begin
        if (mcu_req) m_own = 2;
        else if (host_req) m_own = 1;
      end else if (m_own == 1) begin
        if (host_done) m_own = 0;
      end else begin
        if (mcu_done) m_own = 0;
      end
      m_av = (m_own != 2);
      hist.push_front(m_rst);
      void'(hist.pop_back());
      m_done = hist[LAT-1];
      if (ctl_wr) begin
        m_en = ctl_en;
        m_rst = ctl_rst;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R1 code", own_status, m_own);
      chk("R3 avail", avail, m_av);
      chk("R10 enable", chan_en, m_en);
      chk("R10 reset bit", chan_rst, m_rst);
      chk("R11 reset done", rst_done, m_done);
    end
  end

  task automatic cyc(bit hr, bit hd, bit mr, bit md, bit cw = 0, bit ce = 0, bit cr = 0);
    host_req = hr; host_done = hd; mcu_req = mr; mcu_done = md;
    ctl_wr = cw; ctl_en = ce; ctl_rst = cr;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    cyc(0, 0, 0, 0);
    // R1 reset state
    chk("R1 reset code", own_status, 0);
    chk("R1 reset avail", avail, 1);
    chk("R1 reset enable", chan_en, 0);
    chk("R1 reset done", rst_done, 0);

    // R10 enable and reset raised together
    cyc(0, 0, 0, 0, 1, 1, 1);
    chk("R10 en set", chan_en, 1);
    chk("R10 rst set", chan_rst, 1);
    for (int i = 0; i < LAT - 1; i++) cyc(0, 0, 0, 0);
    chk("R11 done not yet", rst_done, 0);
    cyc(0, 0, 0, 0);
    chk("R11 done rises", rst_done, 1);
    cyc(0, 0, 0, 0, 1, 1, 0);
    chk("R10 rst clear", chan_rst, 0);
    chk("R10 en kept", chan_en, 1);
    for (int i = 0; i < LAT - 1; i++) cyc(0, 0, 0, 0);
    chk("R11 done still high", rst_done, 1);
    cyc(0, 0, 0, 0);
    chk("R11 done falls", rst_done, 0);

    // R2 host acquires
    cyc(1, 0, 0, 0);
    chk("R2 host owns", own_status, 1);
    chk("R3 avail host", avail, 1);
    cyc(0, 0, 1, 0);
    chk("R9 mcu req ignored", own_status, 1);
    cyc(0, 0, 0, 1);
    chk("R8 mcu done ignored", own_status, 1);
    cyc(1, 1, 0, 0);
    chk("R6 host release", own_status, 0);

    // R4 simultaneous request
    cyc(1, 0, 1, 0);
    chk("R4 mcu wins", own_status, 2);
    chk("R3 avail low", avail, 0);
    cyc(1, 0, 0, 0);
    chk("R5 host req fails", own_status, 2);
    chk("R5 avail still low", avail, 0);
    cyc(0, 1, 0, 0);
    chk("R8 host done ignored", own_status, 2);
    cyc(0, 0, 0, 1);
    chk("R7 mcu release", own_status, 0);
    chk("R3 avail back", avail, 1);

    // R8 releases in idle
    cyc(0, 1, 0, 1);
    chk("R8 idle releases", own_status, 0);

    // R9 waiting controller granted after host release
    cyc(1, 0, 0, 0);
    chk("R2 host again", own_status, 1);
    cyc(0, 1, 1, 0);
    chk("R9 idle after release", own_status, 0);
    cyc(0, 0, 1, 0);
    chk("R9 mcu granted", own_status, 2);
    cyc(0, 0, 0, 1);
    chk("R7 mcu release again", own_status, 0);
    cyc(0, 0, 0, 0);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule